// File: doc/BRIEF.md
# Stereo Pan Mixer for Sound Generators

This block places the mono output of several sound generators in a stereo image. Each generator owns a signed 8-bit balance register, and that value sets how much of the generator's sample goes to the left channel and how much to the right. Full left, centre and full right are fixed points, and the values in between are interpolated. On every sample strobe the block scales each generator's sample into a left and a right contribution and sums the contributions per channel. It then saturates each sum to the signed output range and presents the left and right results together with a one-cycle valid pulse.

The balance registers are reached through a simple byte-addressed write port and a combinational read port. The address space is split into 64-byte windows, one per generator, and the balance register sits at the last byte of each window. Balance values are copied into a snapshot when a strobe arrives. A frame is therefore mixed with one consistent set of gains, even when software changes them while the arithmetic is in flight. Reset is asserted asynchronously and released synchronously inside the block.

Top module: `pan_mixer`

## Requirements
- R1: Generator v's balance register is at byte address v*64+63 (offset 0x3F of its 64-byte window). A write to any other address changes no register and no later mix. A read of any other address returns 0.
- R2: Every balance register resets to 0, and reading it returns the last byte written to it, for all 256 byte values.
- R3: The balance byte is two's complement. The value -128 (0x80) behaves exactly like -127: the sample goes wholly to the left output and the right contribution is 0.
- R4: With clamped balance p, n_R = p+127 and n_L = 127-p. Each gain is G = floor((n*65536+127)/254). Each contribution is floor((s*G+32768)/65536). As a result, +127 gives right = s and left = 0, and 0 gives floor((s+1)/2) on both sides.
- R5: The contributions of all generators are summed per channel, and each sum is saturated to the range -32768..32767.
- R6: A strobe sampled at clock edge k produces out_valid high for exactly the cycle after edge k+1, with the new outputs visible from that edge.
- R7: Between valid pulses, out_left and out_right hold their values whatever the sample inputs do.
- R8: A balance write takes part in a strobe's mix only if it is taken at an edge before the strobe's edge. A write taken at the same edge as the strobe applies from the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write enable |
| wr_addr | input | ADDR_W | Register write byte address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | ADDR_W | Register read byte address |
| rd_data | output | 8 | Read data; balance value or 0 |
| sample_valid | input | 1 | Sample strobe for all generators |
| voice_in | input | NUM_VOICES*SAMPLE_W | Signed mono samples, generator v at bits [v*SAMPLE_W +: SAMPLE_W] |
| out_valid | output | 1 | One-cycle pulse marking a new output pair |
| out_left | output | OUT_W | Saturated signed left sample |
| out_right | output | OUT_W | Saturated signed right sample |

## Verification
The bench builds the mixer with two generators and 16-bit samples and outputs. This keeps the address map at seven bits and makes a sum of two full-scale contributions the natural way to reach both saturation limits. With only two generators, all 256 balance codes can be swept against four sample values, including both sample extremes, while the second generator is held silent. Every readback value and the clamp of -128 are covered the same way. Further directed frames with both generators active probe the saturation limits, ignored addresses, output holding, and a write landing on the same edge as a strobe.

// File: rtl/pan_mix_pkg.sv
package pan_mix_pkg;

  localparam int WIN_LSB   = 6;
  localparam int PAN_OFFS  = 63;
  localparam int GAIN_W    = 17;
  localparam int GAIN_FRAC = 16;
  localparam int PAN_W     = 8;

  // Rounded gain for n steps out of 254, scaled by 2^16.
  function automatic logic [GAIN_W-1:0] steps_to_gain(input logic [PAN_W-1:0] n);
    logic [24:0] num;
    logic [24:0] quo;
    num = {1'b0, n, 16'h0000} + 25'd127;
    quo = num / 25'd254;
    return quo[GAIN_W-1:0];
  endfunction

endpackage

// File: rtl/pan_regfile.sv
module pan_regfile #(
  parameter int NUM_VOICES = 4,
  parameter int ADDR_W     = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [7:0]              wr_data,
  input  logic [ADDR_W-1:0]       rd_addr,
  output logic [7:0]              rd_data,
  output logic [NUM_VOICES*8-1:0] pan_flat
);
  import pan_mix_pkg::*;

  logic [7:0] pan_q   [NUM_VOICES];
  logic [7:0] pan_nxt [NUM_VOICES];
  logic       pan_en  [NUM_VOICES];

  for (genvar v = 0; v < NUM_VOICES; v++) begin : g_reg
    localparam logic [ADDR_W-1:0] REG_ADDR = ADDR_W'(v * (1 << WIN_LSB) + PAN_OFFS);

    always_comb begin
      pan_en[v]  = wr_en && (wr_addr == REG_ADDR);
      pan_nxt[v] = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pan_q[v] <= '0;
      else if (pan_en[v]) pan_q[v] <= pan_nxt[v];
    end

    assign pan_flat[v*8 +: 8] = pan_q[v];
  end

  always_comb begin
    rd_data = '0;
    for (int v = 0; v < NUM_VOICES; v++) begin
      if (rd_addr == ADDR_W'(v * (1 << WIN_LSB) + PAN_OFFS)) rd_data = pan_q[v];
    end
  end

endmodule

// File: rtl/pan_voice_scale.sv
module pan_voice_scale #(
  parameter int SAMPLE_W  = 16,
  parameter int CONTRIB_W = SAMPLE_W + 2
) (
  input  logic signed [SAMPLE_W-1:0]  sample,
  input  logic        [7:0]           pan,
  output logic signed [CONTRIB_W-1:0] contrib_l,
  output logic signed [CONTRIB_W-1:0] contrib_r
);
  import pan_mix_pkg::*;

  localparam int PROD_W = SAMPLE_W + GAIN_W + 1;

  logic signed [7:0]        pan_c;
  logic signed [8:0]        steps_r;
  logic signed [8:0]        steps_l;
  logic        [GAIN_W-1:0] gain_r;
  logic        [GAIN_W-1:0] gain_l;
  logic signed [PROD_W-1:0] rnd_r;
  logic signed [PROD_W-1:0] rnd_l;
  logic                     unused_lsb;

  always_comb begin
    pan_c   = (pan == 8'h80) ? 8'sh81 : $signed(pan);
    steps_r = {pan_c[7], pan_c} + 9'sd127;
    steps_l = 9'sd127 - {pan_c[7], pan_c};
    gain_r  = steps_to_gain(steps_r[7:0]);
    gain_l  = steps_to_gain(steps_l[7:0]);
    rnd_r   = sample * $signed({1'b0, gain_r}) + PROD_W'(32768);
    rnd_l   = sample * $signed({1'b0, gain_l}) + PROD_W'(32768);
  end

  assign contrib_r  = rnd_r[PROD_W-1:GAIN_FRAC];
  assign contrib_l  = rnd_l[PROD_W-1:GAIN_FRAC];
  assign unused_lsb = ^{rnd_r[GAIN_FRAC-1:0], rnd_l[GAIN_FRAC-1:0], steps_r[8], steps_l[8]};

endmodule

// File: rtl/pan_sum_sat.sv
module pan_sum_sat #(
  parameter int NUM_VOICES = 4,
  parameter int IN_W       = 18,
  parameter int OUT_W      = 16
) (
  input  logic [NUM_VOICES*IN_W-1:0] terms,
  output logic signed [OUT_W-1:0]    result
);
  localparam int SUM_W = IN_W + $clog2(NUM_VOICES) + 1;
  localparam logic signed [SUM_W-1:0] SAT_HI = SUM_W'((64'sd1 <<< (OUT_W - 1)) - 64'sd1);
  localparam logic signed [SUM_W-1:0] SAT_LO = -SAT_HI - SUM_W'(1);

  logic signed [SUM_W-1:0] acc;

  always_comb begin
    acc = '0;
    for (int v = 0; v < NUM_VOICES; v++) begin
      acc = acc + SUM_W'($signed(terms[v*IN_W +: IN_W]));
    end
    if (acc > SAT_HI)      result = SAT_HI[OUT_W-1:0];
    else if (acc < SAT_LO) result = SAT_LO[OUT_W-1:0];
    else                   result = acc[OUT_W-1:0];
  end

endmodule

// File: rtl/pan_mixer.sv
module pan_mixer #(
  parameter int NUM_VOICES = 4,
  parameter int SAMPLE_W   = 16,
  parameter int OUT_W      = 16,
  parameter int ADDR_W     = $clog2(NUM_VOICES * 64)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic [ADDR_W-1:0]              wr_addr,
  input  logic [7:0]                     wr_data,
  input  logic [ADDR_W-1:0]              rd_addr,
  output logic [7:0]                     rd_data,
  input  logic                           sample_valid,
  input  logic [NUM_VOICES*SAMPLE_W-1:0] voice_in,
  output logic                           out_valid,
  output logic signed [OUT_W-1:0]        out_left,
  output logic signed [OUT_W-1:0]        out_right
);
  localparam int CONTRIB_W = SAMPLE_W + 2;

  logic [1:0]                     rst_pipe;
  logic                           rst_q;
  logic [NUM_VOICES*8-1:0]        pan_live;
  logic [NUM_VOICES*8-1:0]        snap_pan;
  logic [NUM_VOICES*SAMPLE_W-1:0] snap_smp;
  logic                           snap_vld;
  logic [NUM_VOICES*CONTRIB_W-1:0] terms_l;
  logic [NUM_VOICES*CONTRIB_W-1:0] terms_r;
  logic signed [OUT_W-1:0]        mix_l;
  logic signed [OUT_W-1:0]        mix_r;
  logic signed [OUT_W-1:0]        out_l_nxt;
  logic signed [OUT_W-1:0]        out_r_nxt;

  // reset: asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q = rst_pipe[1];

  pan_regfile #(.NUM_VOICES(NUM_VOICES), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_q), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .pan_flat(pan_live)
  );

  // stage 1: snapshot of balance values and samples on the strobe
  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      snap_pan <= '0;
      snap_smp <= '0;
      snap_vld <= 1'b0;
    end else begin
      snap_vld <= sample_valid;
      if (sample_valid) begin
        snap_pan <= pan_live;
        snap_smp <= voice_in;
      end
    end
  end

  for (genvar v = 0; v < NUM_VOICES; v++) begin : g_voice
    logic signed [CONTRIB_W-1:0] c_l;
    logic signed [CONTRIB_W-1:0] c_r;
    pan_voice_scale #(.SAMPLE_W(SAMPLE_W), .CONTRIB_W(CONTRIB_W)) u_scale (
      .sample(snap_smp[v*SAMPLE_W +: SAMPLE_W]), .pan(snap_pan[v*8 +: 8]),
      .contrib_l(c_l), .contrib_r(c_r)
    );
    assign terms_l[v*CONTRIB_W +: CONTRIB_W] = c_l;
    assign terms_r[v*CONTRIB_W +: CONTRIB_W] = c_r;
  end

  pan_sum_sat #(.NUM_VOICES(NUM_VOICES), .IN_W(CONTRIB_W), .OUT_W(OUT_W)) u_sum_l (
    .terms(terms_l), .result(mix_l)
  );
  pan_sum_sat #(.NUM_VOICES(NUM_VOICES), .IN_W(CONTRIB_W), .OUT_W(OUT_W)) u_sum_r (
    .terms(terms_r), .result(mix_r)
  );

  // stage 2: output registers, enabled by the snapshot valid
  always_comb begin
    out_l_nxt = snap_vld ? mix_l : out_left;
    out_r_nxt = snap_vld ? mix_r : out_right;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      out_left  <= '0;
      out_right <= '0;
      out_valid <= 1'b0;
    end else begin
      out_left  <= out_l_nxt;
      out_right <= out_r_nxt;
      out_valid <= snap_vld;
    end
  end

endmodule

// File: rtl/pan_mixer_checker.sv
module pan_mixer_checker #(
  parameter int NUM_VOICES = 4,
  parameter int OUT_W      = 16,
  parameter int ADDR_W     = 8
) (
  input logic                    clk,
  input logic                    rst_q,
  input logic                    sample_valid,
  input logic                    out_valid,
  input logic [OUT_W-1:0]        out_left,
  input logic [OUT_W-1:0]        out_right,
  input logic [ADDR_W-1:0]       rd_addr,
  input logic [7:0]              rd_data,
  input logic [NUM_VOICES*8-1:0] snap_pan
);

  // R6: a strobe yields a valid pulse two edges later
  a_r6_latency: assert property (@(posedge clk) disable iff (!rst_q)
    sample_valid |=> ##1 out_valid);

  // R7: outputs only move with a valid pulse
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_q)
    !out_valid |-> ($stable(out_left) && $stable(out_right)));

  // R1: addresses off the last byte of a window read as zero
  a_r1_rd_nonpan: assert property (@(posedge clk) disable iff (!rst_q)
    (rd_addr[5:0] != 6'h3F) |-> (rd_data == 8'h00));

  // R8: the gain snapshot changes only on a strobe
  a_r8_snap_hold: assert property (@(posedge clk) disable iff (!rst_q)
    !sample_valid |=> $stable(snap_pan));

endmodule

bind pan_mixer pan_mixer_checker #(
  .NUM_VOICES(NUM_VOICES), .OUT_W(OUT_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst_q(rst_q), .sample_valid(sample_valid), .out_valid(out_valid),
  .out_left(out_left), .out_right(out_right), .rd_addr(rd_addr), .rd_data(rd_data),
  .snap_pan(snap_pan)
);

// File: tb/pan_mixer_bench.sv
`timescale 1ns/1ps
module pan_mixer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 2;
  localparam int SW = 16;
  localparam int OW = 16;
  localparam int AW = $clog2(NV * 64);

  logic              clk = 1'b0;
  logic              rst_n;
  logic              wr_en;
  logic [AW-1:0]     wr_addr;
  logic [7:0]        wr_data;
  logic [AW-1:0]     rd_addr;
  logic [7:0]        rd_data;
  logic              sample_valid;
  logic [NV*SW-1:0]  voice_in;
  logic              out_valid;
  logic signed [OW-1:0] out_left;
  logic signed [OW-1:0] out_right;

  int total = 0;
  int bad   = 0;
  bit done  = 0;
  int pan_m [NV];

  always #(CLK_PERIOD/2) clk = ~clk;

  pan_mixer #(.NUM_VOICES(NV), .SAMPLE_W(SW), .OUT_W(OW)) u_pan_mixer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .sample_valid(sample_valid),
    .voice_in(voice_in), .out_valid(out_valid), .out_left(out_left), .out_right(out_right)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int contrib(input int s, input int n);
    longint g, r;
    g = (longint'(n) * 65536 + 127) / 254;
    r = longint'(s) * g + 32768;
    return int'(r >>> 16);
  endfunction

  function automatic int sat16(input int x);
    if (x > 32767) return 32767;
    if (x < -32768) return -32768;
    return x;
  endfunction

  function automatic int pan_clamp(input int p);
    return (p == -128) ? -127 : p;
  endfunction

  function automatic int exp_mix(input int s0, input int s1, input bit right);
    int acc, p;
    acc = 0;
    for (int v = 0; v < NV; v++) begin
      p = pan_clamp(pan_m[v]);
      acc += contrib((v == 0) ? s0 : s1, right ? (p + 127) : (127 - p));
    end
    return sat16(acc);
  endfunction

  function automatic logic [AW-1:0] pan_addr(input int v);
    return AW'(v * 64 + 63);
  endfunction

  task automatic write_raw(input logic [AW-1:0] a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = 8'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic write_pan(input int v, input int p);
    write_raw(pan_addr(v), p);
    pan_m[v] = p;
  endtask

  task automatic read_chk(input string tag, input logic [AW-1:0] a, input int exp);
    @(negedge clk);
    rd_addr = a;
    #1;
    chk(tag, int'(rd_data), exp & 255);
  endtask

  // Strobe sampled at edge k; outputs and valid visible after edge k+1.
  task automatic strobe(input string tag, input int s0, input int s1);
    int el, er;
    el = exp_mix(s0, s1, 1'b0);
    er = exp_mix(s0, s1, 1'b1);
    @(negedge clk);
    voice_in = {16'(s1), 16'(s0)}; sample_valid = 1'b1;
    @(negedge clk);
    sample_valid = 1'b0;
    @(negedge clk);
    chk({tag, " left"},  int'(out_left),  el);
    chk({tag, " right"}, int'(out_right), er);
    chk("R6 valid pulse", int'(out_valid), 1);
    @(negedge clk);
    chk("R6 valid one cycle", int'(out_valid), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int samples [4];
    int p0, p1, s;
    samples = '{12345, -32768, 32767, -1};
    rst_n = 1'b0; wr_en = 0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    sample_valid = 0; voice_in = '0;
    for (int v = 0; v < NV; v++) pan_m[v] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2: reset state
    chk("R2 reset out_valid", int'(out_valid), 0);
    chk("R2 reset left", int'(out_left), 0);
    chk("R2 reset right", int'(out_right), 0);
    read_chk("R2 reset pan0", pan_addr(0), 0);
    read_chk("R2 reset pan1", pan_addr(1), 0);

    // R2: readback of every byte value
    for (int d = 0; d < 256; d++) begin
      write_pan(1, d - 256 * (d / 128));
      read_chk("R2 readback", pan_addr(1), d);
    end
    write_pan(1, 0);

    // R1: other addresses neither store nor read back
    write_pan(0, 40);
    write_raw(AW'(62), 8'h55);
    write_raw(AW'(64), 8'h55);
    write_raw(AW'(0), 8'h55);
    read_chk("R1 pan0 kept", pan_addr(0), 40);
    read_chk("R1 pan1 kept", pan_addr(1), 0);
    read_chk("R1 nonpan read 62", AW'(62), 0);
    read_chk("R1 nonpan read 0", AW'(0), 0);
    strobe("R1 mix after ignored writes", 20000, 8000);

    // R4 and R3: all balance codes against several samples, voice 1 silent
    for (int p = -128; p < 128; p++) begin
      write_pan(0, p);
      for (int i = 0; i < 4; i++) begin
        strobe((p == -128) ? "R3 clamp" : "R4 gain", samples[i], 0);
      end
    end
    // R4 endpoint and centre stated directly
    write_pan(0, 127);
    strobe("R4 full right", -20001, 0);
    chk("R4 right equals sample", int'(out_right), -20001);
    chk("R4 left zero", int'(out_left), 0);
    write_pan(0, 0);
    strobe("R4 centre", 777, 0);
    chk("R4 centre half", int'(out_left), 389);
    write_pan(0, -128);
    strobe("R3 minus 128", 30001, 0);
    chk("R3 all left", int'(out_left), 30001);
    chk("R3 right zero", int'(out_right), 0);

    // R5: sums and saturation with both voices
    write_pan(0, 127); write_pan(1, 127);
    strobe("R5 sat high", 30000, 30000);
    chk("R5 clip 32767", int'(out_right), 32767);
    strobe("R5 sat low", -30000, -30000);
    chk("R5 clip -32768", int'(out_right), -32768);
    write_pan(0, -127); write_pan(1, -128);
    strobe("R5 sat left", 32767, 1);
    write_pan(0, 0); write_pan(1, 0);
    strobe("R5 centre sum", 30000, 30000);
    for (int k = 0; k < 40; k++) begin
      p0 = (k * 37) % 256 - 128; p1 = (k * 91 + 5) % 256 - 128;
      s = (k * 7919) % 65536 - 32768;
      write_pan(0, p0); write_pan(1, p1);
      strobe("R5 pair", s, -s / 3 + 11111);
    end

    // R7: outputs hold without a strobe
    write_pan(0, 60); write_pan(1, -60);
    strobe("R7 setup", 10000, -5000);
    p0 = int'(out_left); p1 = int'(out_right);
    @(negedge clk); voice_in = {16'h7FFF, 16'h8000};
    repeat (3) @(negedge clk);
    chk("R7 left held", int'(out_left), p0);
    chk("R7 right held", int'(out_right), p1);

    // R8: write at the strobe edge applies only to the next strobe
    @(negedge clk);
    voice_in = {16'(0), 16'(12000)}; sample_valid = 1'b1;
    wr_en = 1'b1; wr_addr = pan_addr(0); wr_data = 8'd127;
    @(negedge clk);
    sample_valid = 1'b0; wr_en = 1'b0;
    @(negedge clk);
    chk("R8 old gain left", int'(out_left), contrib(12000, 127 - 60));
    chk("R8 old gain right", int'(out_right), contrib(12000, 127 + 60));
    pan_m[0] = 127;
    strobe("R8 new gain", 12000, 0);
    chk("R8 new right", int'(out_right), 12000);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule